// File: doc/BRIEF.md
# Equal-Precision Frequency Meter

This block measures the frequency of an unknown digital input against the reference clock that runs it. Two counters share one gate window. The first counts reference cycles and the second counts rising edges of the signal under test. Software opens and closes the window through a request bit, then reads both counts. The unknown frequency equals the reference frequency times the test count divided by the reference count. With the default 50 MHz reference, the result in MHz is 50 times the test count divided by the reference count.

The requested gate takes effect only on rising edges of the signal under test. The window therefore spans a whole number of test periods, and the test count carries no plus-or-minus-one error. The unknown input first passes through a flop synchronizer into the reference domain. No logic is clocked by the unknown signal.

Software runs three steps. It writes clear low to zero both counts. It raises clear and the gate request together. Later it drops the gate request while leaving clear high, which keeps the counts, and then reads them once the done flag is up.

Top module: `freqm_core`

## Requirements
- R1: While `rst` is high at a clock edge, both counts and `done` are zero after that edge.
- R2: While `clr_n` is 0, both counts are held at zero and `done` is 0, whatever `gate_req` and `sig_in` do.
- R3: The effective gate opens only at the first synchronized rising edge of `sig_in` seen while `gate_req` and `clr_n` are both 1. If no rising edge arrives, both counts stay at zero and `done` stays 0.
- R4: While the effective gate is open, the reference count rises by exactly one per clock cycle.
- R5: While the effective gate is open, the test count rises by one for each rising edge of `sig_in`. For a test period of P reference cycles, the final counts satisfy reference count = P × test count.
- R6: After `gate_req` returns to 0, the effective gate closes at the next synchronized rising edge of `sig_in`. From then on, both counts hold their values for as long as `clr_n` stays 1.
- R7: `done` is 1 from the closing edge until `clr_n` goes to 0.
- R8: Each counter stops at its all-ones value instead of wrapping.
- R9: Once a measurement is done, raising `gate_req` again without a clear has no effect on either count or on `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; everything is clocked by it |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Signal under test, asynchronous to `clk` |
| gate_req | input | 1 | Software gate request; 1 asks for the window to open |
| clr_n | input | 1 | Software clear; 0 zeroes and holds both counts |
| ref_count | output | CNT_W (32) | Reference cycles counted inside the window |
| sig_count | output | CNT_W (32) | Rising edges of `sig_in` counted inside the window |
| done | output | 1 | Window has closed and the counts are final |

## Verification
The bench checks the exact ratio between the two counts over many random periods, duty cycles and window lengths. A gate that is not aligned to test edges fails this check, because it leaves a stray test edge or a partial period in the counts. It drives a dead input to confirm that a gate without edges never opens. A design that opened on the request alone would show a nonzero reference count there. It re-requests the gate after done to catch a design that restarts without a clear. It uses a narrow second instance to make the counters run past all-ones, which exposes wrap-around as a small count.

// File: rtl/freqm_pkg.sv
package freqm_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_OPEN = 2'd1,
    GATE_DONE = 2'd2
  } gate_state_t;
endpackage

// File: rtl/freqm_sync.sv
// Brings the test signal into the reference domain and flags its rising edges.
module freqm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  localparam int TOP = STAGES;

  logic [TOP:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[TOP-1:0], sig_in};
  end

  // shift_q[TOP-1] is the last synchronized sample; shift_q[TOP] is one older
  assign rise = shift_q[TOP-1] & ~shift_q[TOP];
endmodule

// File: rtl/freqm_gate.sv
// Effective gate: opens and closes only on synchronized test edges.
module freqm_gate
  import freqm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic gate_req,
  input  logic rise,
  output logic gate_open,
  output logic done
);
  gate_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_IDLE: if (gate_req && rise)  state_d = GATE_OPEN;
      GATE_OPEN: if (!gate_req && rise) state_d = GATE_DONE;
      GATE_DONE: state_d = GATE_DONE;
      default:   state_d = GATE_IDLE;
    endcase
    if (!clr_n) state_d = GATE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_d == GATE_DONE);
    end
  end

  assign gate_open = (state_q == GATE_OPEN);
endmodule

// File: rtl/freqm_counter.sv
// Saturating up-counter with a synchronous clear.
module freqm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !clr_n)         cnt <= '0;
    else if (en && cnt != FULL) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/freqm_core.sv
module freqm_core #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic             gate_req,
  input  logic             clr_n,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] sig_count,
  output logic             done
);
  logic rise;
  logic gate_open;

  freqm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sig_in(sig_in), .rise(rise)
  );

  freqm_gate u_gate (
    .clk(clk), .rst(rst), .clr_n(clr_n), .gate_req(gate_req),
    .rise(rise), .gate_open(gate_open), .done(done)
  );

  freqm_counter #(.CNT_W(CNT_W)) u_ref_cnt (
    .clk(clk), .rst(rst), .clr_n(clr_n), .en(gate_open), .cnt(ref_count)
  );

  freqm_counter #(.CNT_W(CNT_W)) u_sig_cnt (
    .clk(clk), .rst(rst), .clr_n(clr_n), .en(gate_open && rise), .cnt(sig_count)
  );
endmodule

// File: rtl/freqm_chk.sv
module freqm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_n,
  input logic [CNT_W-1:0] ref_count,
  input logic [CNT_W-1:0] sig_count,
  input logic             done
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (ref_count == '0 && sig_count == '0 && !done));

  // R4
  ref_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && sig_count != '0 && !done && ref_count != FULL)
      |=> ref_count == CNT_W'($past(ref_count) + 1'b1));

  // R5
  sig_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_n) |-> (sig_count == $past(sig_count) ||
                      sig_count == CNT_W'($past(sig_count) + 1'b1)));

  // R6
  hold_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done && clr_n) |=> ($stable(ref_count) && $stable(sig_count)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && clr_n) |=> done);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ref_count) == FULL && $past(clr_n)) |-> ref_count == FULL);
endmodule

bind freqm_core freqm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n),
  .ref_count(ref_count), .sig_count(sig_count), .done(done)
);

// File: tb/sim_freqm_core.sv
`timescale 1ns/1ps
module sim_freqm_core;
  localparam int W  = 32;
  localparam int SW = 6;
  localparam longint SFULL = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic gate_req = 1'b0;
  logic clr_n = 1'b0;
  logic [W-1:0]  ref_count, sig_count;
  logic [SW-1:0] ref_s, sig_s;
  logic done, done_s;

  int n_checks = 0;
  int n_fail = 0;
  int per = 4;
  int hi = 2;
  bit sig_en = 1'b0;

  always #10 clk = ~clk;

  freqm_core u0 (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_req(gate_req), .clr_n(clr_n),
    .ref_count(ref_count), .sig_count(sig_count), .done(done)
  );

  freqm_core #(.CNT_W(SW)) u1 (
    .clk(clk), .rst(rst), .sig_in(sig_in), .gate_req(gate_req), .clr_n(clr_n),
    .ref_count(ref_s), .sig_count(sig_s), .done(done_s)
  );

  // test signal: high for hi cycles, low for per-hi cycles, driven at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (sig_en) begin
        sig_in = 1'b1;
        repeat (hi - 1) @(negedge clk);
        @(negedge clk);
        sig_in = 1'b0;
        repeat (per - hi - 1) @(negedge clk);
      end else sig_in = 1'b0;
    end
  end

  function automatic longint sat_of(longint v);
    return (v > SFULL) ? SFULL : v;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr_n = 1'b0;
    gate_req = 1'b0;
    cyc(2);
    check(ref_count == 0 && sig_count == 0, "R2 counts zero", ref_count + sig_count, 0);
    check(done == 0, "R2 done low", done, 0);
    clr_n = 1'b1;
    cyc(1);
  endtask

  // one measurement with window of about m cycles; checks ratio, bounds, hold
  task automatic measure(int m);
    longint r0, s0;
    int lo, hi_n, t;
    do_clear();
    gate_req = 1'b1;
    cyc(m);
    gate_req = 1'b0;
    t = 0;
    while (!done && t < 2 * per + 20) begin cyc(1); t++; end
    check(done == 1, "R7 done after close", done, 1);
    check(ref_count == longint'(sig_count) * per, "R5 ratio", ref_count,
          longint'(sig_count) * per);
    lo   = m / per - 1;
    hi_n = m / per + 2;
    check(sig_count >= lo && sig_count <= hi_n, "R5 edge count range", sig_count, m / per);
    check(ref_s == sat_of(ref_count), "R8 narrow ref saturates", ref_s, sat_of(ref_count));
    check(sig_s == sat_of(sig_count), "R8 narrow sig saturates", sig_s, sat_of(sig_count));
    r0 = ref_count; s0 = sig_count;
    cyc(3 * per + 5);
    check(ref_count == r0 && sig_count == s0, "R6 counts hold", ref_count, r0);
    check(done == 1, "R7 done sticky", done, 1);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    cyc(3);
    // R1: reset state
    check(ref_count == 0 && sig_count == 0, "R1 counts after reset", ref_count + sig_count, 0);
    check(done == 0, "R1 done after reset", done, 0);
    rst = 1'b0;
    clr_n = 1'b1;
    cyc(2);

    // R3: no test edges, gate never opens
    sig_en = 1'b0;
    gate_req = 1'b1;
    cyc(60);
    gate_req = 1'b0;
    cyc(10);
    check(ref_count == 0 && sig_count == 0, "R3 no edge no count", ref_count + sig_count, 0);
    check(done == 0, "R3 no edge no done", done, 0);

    // R2: clear held low blocks counting even with edges and request
    per = 5; hi = 2; sig_en = 1'b1;
    cyc(20);
    clr_n = 1'b0;
    gate_req = 1'b1;
    cyc(40);
    check(ref_count == 0 && sig_count == 0, "R2 clear holds zero", ref_count + sig_count, 0);
    check(done == 0, "R2 clear holds done", done, 0);
    gate_req = 1'b0;
    clr_n = 1'b1;
    cyc(5);

    // R4: while open reference count steps by one each cycle
    do_clear();
    per = 6; hi = 3;
    cyc(20);
    gate_req = 1'b1;
    cyc(3 * per);
    for (int k = 0; k < 5; k++) begin
      longint a;
      a = ref_count;
      cyc(1);
      check(ref_count == a + 1, "R4 ref step", ref_count, a + 1);
    end
    gate_req = 1'b0;
    cyc(3 * per);

    // directed fastest signal: period 2
    per = 2; hi = 1;
    cyc(10);
    measure(300);

    // R9: re-request after done is ignored
    begin
      longint r0, s0;
      r0 = ref_count; s0 = sig_count;
      gate_req = 1'b1;
      cyc(40);
      check(ref_count == r0 && sig_count == s0, "R9 re-request ignored", ref_count, r0);
      check(done == 1, "R9 done stays", done, 1);
      gate_req = 1'b0;
      cyc(2);
    end

    // random periods, duties and windows
    for (int i = 0; i < 10; i++) begin
      int p, m;
      p = $urandom_range(3, 25);
      m = $urandom_range(40, 2000);
      per = p;
      hi = $urandom_range(1, p - 1);
      cyc(3 * 25);
      measure(m);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule